// File: doc/BRIEF.md
# Rotating XOR Configuration Checksum Engine

This block checks the integrity of a configuration store made of 16-bit words. After a one-cycle start request it reads, in ascending order, every word of the covered region. It folds each word into a 16-bit running value: the word is XORed in, then the value is rotated left by one position. The running value begins at 0xAAAA. The word that holds the stored check value sits directly after the covered region and is not part of the computation. It is read once, at the end of the walk, and compared with the computed value. The factory area above it is never addressed.

The engine drives a read port with one cycle of latency. It presents an address and a read enable, and the store returns the data on the following cycle. The engine keeps a tag pipeline one stage deep, so each returning word is handled as it arrives and the walk never stalls. When the walk completes, a one-cycle done pulse marks the result. The computed value stays on its output and the match flag stays valid until the next accepted start. A caller that must rewrite the stored word takes the value from the result output. A caller that only verifies the store reads the match flag.

Top module: `rot_xor_csum`

## Requirements
- R1: After reset the engine is idle. The read enable, done and match outputs are 0 and the result output is 0xAAAA.
- R2: Each accepted start reloads the running value with 0xAAAA before the first word is folded in. The outcome of one run therefore does not depend on any earlier run.
- R3: For each covered word, the running value becomes rotl1(value XOR word), where rotl1 moves bit 15 into bit 0 and shifts every other bit up by one.
- R4: While the read enable is high, the read address goes 0x00, 0x01, … up to 0x3F, one step per cycle, with no gaps or repeats. That is 64 reads in total.
- R5: No address at or above 0x40 is ever presented. The contents of words 0x40 and above have no effect on the result or on the match flag.
- R6: Only words 0x00 to 0x3E (63 words) enter the computation. The value stored at word 0x3F changes the match flag and nothing else.
- R7: Read data is taken one cycle after its address. Done is high for exactly one cycle, on the 65th rising edge after the edge that accepts start, and the read enable is low at that point.
- R8: From the done pulse until the next accepted start, result holds the computed value and match is 1 exactly when that value equals word 0x3F.
- R9: A start request made while a run is in progress, including during the last read and the cycle that waits for its data, is ignored. The run neither restarts nor shifts, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests a run; accepted only when idle |
| rd_en | output | 1 | Read request to the configuration store |
| rd_addr | output | 7 | Word address of the read request |
| rd_data | input | 16 | Read data, valid the cycle after rd_en |
| done | output | 1 | One-cycle pulse when the result and match are final |
| result | output | 16 | Running and then final check value |
| match | output | 1 | Computed value equals the stored check word |

## Verification
The bench uses the default parameters: 63 covered words, the check word at 0x3F and a 7-bit address. With these, the full-size store can be swept in full. A single set bit is walked through every bit of every covered word, which is 1008 runs. Because the rotation is linear, these runs show that every position of the fold reaches the result with the correct rotation. Random stores are also run, each with the correct check word and with a corrupted one. Runs with random factory contents confirm that those words have no effect. Start requests placed during the walk, on the last read and in the drain cycle confirm that such requests are ignored.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int unsigned WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ISSUE = 2'd1,
        PH_DRAIN = 2'd2
    } phase_e;

    // Tag that travels one cycle behind a read request, lined up with its data.
    typedef struct packed {
        logic fold;   // returning word belongs to the covered region
        logic check;  // returning word is the stored check value
    } rtag_t;

    function automatic word_t rotl(input word_t v, input int unsigned n);
        return (v << n) | (v >> (WORD_W - n));
    endfunction

endpackage

// File: rtl/rxc_seq.sv
module rxc_seq
    import rxc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned NUM_COVERED = 63
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              load,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output rtag_t             tag_q
);
    localparam logic [ADDR_W-1:0] CHK_A = ADDR_W'(NUM_COVERED);

    phase_e            ph_q;
    logic [ADDR_W-1:0] cnt_q;

    assign load    = start && (ph_q == PH_IDLE);
    assign rd_en   = (ph_q == PH_ISSUE);
    assign rd_addr = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    if (load) begin
                        ph_q  <= PH_ISSUE;
                        cnt_q <= '0;
                    end
                end
                PH_ISSUE: begin
                    if (cnt_q == CHK_A) ph_q <= PH_DRAIN;
                    else                cnt_q <= cnt_q + 1'b1;
                end
                PH_DRAIN: ph_q <= PH_IDLE;
                default:  ph_q <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else begin
            tag_q.fold  <= rd_en && (cnt_q < CHK_A);
            tag_q.check <= rd_en && (cnt_q == CHK_A);
        end
    end

    AST_ADDR_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> rd_addr == '0) else $error("first address not zero"); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> rd_addr == ADDR_W'($past(rd_addr) + 1'b1))
        else $error("address not ascending by one"); // R4
    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> rd_addr <= CHK_A) else $error("address beyond check word"); // R5
    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (start && rd_en && rd_addr != CHK_A) |=> (rd_en && rd_addr == ADDR_W'($past(rd_addr) + 1'b1)))
        else $error("start disturbed a running walk"); // R9

endmodule

// File: rtl/rxc_accum.sv
module rxc_accum
    import rxc_pkg::*;
#(
    parameter word_t       SEED = 16'hAAAA,
    parameter int unsigned ROT  = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  fold,
    input  word_t data,
    output word_t acc
);
    always_ff @(posedge clk) begin
        if (rst || load) acc <= SEED;
        else if (fold)   acc <= rotl(acc ^ data, ROT);
    end

    AST_FOLD_CHANGES: assert property (@(posedge clk) disable iff (rst)
        (!load && !fold) |=> $stable(acc)) else $error("accumulator moved without a fold"); // R3

endmodule

// File: rtl/rxc_compare.sv
module rxc_compare
    import rxc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  check,
    input  word_t acc,
    input  word_t data,
    output logic  done,
    output logic  match
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            match <= 1'b0;
        end else begin
            done <= check;
            if (load)       match <= 1'b0;
            else if (check) match <= (acc == data);
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R7
    AST_MATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !check) |=> $stable(match)) else $error("match changed outside a compare"); // R8

endmodule

// File: rtl/rot_xor_csum.sv
module rot_xor_csum
    import rxc_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned NUM_COVERED = 63,
    parameter word_t       SEED        = 16'hAAAA,
    parameter int unsigned ROT         = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              match
);
    logic  load;
    rtag_t tag_q;
    word_t acc;

    rxc_seq #(.ADDR_W(ADDR_W), .NUM_COVERED(NUM_COVERED)) u_seq (
        .clk(clk), .rst(rst), .start(start), .load(load),
        .rd_en(rd_en), .rd_addr(rd_addr), .tag_q(tag_q)
    );

    rxc_accum #(.SEED(SEED), .ROT(ROT)) u_acc (
        .clk(clk), .rst(rst), .load(load), .fold(tag_q.fold),
        .data(rd_data), .acc(acc)
    );

    rxc_compare u_cmp (
        .clk(clk), .rst(rst), .load(load), .check(tag_q.check),
        .acc(acc), .data(rd_data), .done(done), .match(match)
    );

    assign result = acc;

    AST_SEED_AT_WALK: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> result == SEED) else $error("walk began without seed"); // R2
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_en) else $error("done while reading"); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(result)) else $error("result moved after done"); // R8

endmodule

// File: tb/tb_rot_xor_csum.sv
`timescale 1ns/1ps
module tb_rot_xor_csum;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        rd_en;
    logic [6:0]  rd_addr;
    logic [15:0] rd_data;
    logic        done;
    logic [15:0] result;
    logic        match;

    int unsigned n_vec  = 0;
    int unsigned n_fail = 0;

    logic [15:0] mem [0:127];

    always #2.5 clk = ~clk;

    rot_xor_csum dut (
        .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .done(done), .result(result), .match(match)
    );

    // Store model with one cycle of read latency (R7)
    always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    // Address monitor (R4, R5)
    int unsigned mon_next, mon_bad, mon_fac, mon_cnt;
    always @(negedge clk) begin
        if (!rst && rd_en) begin
            if (rd_addr != 7'(mon_next)) mon_bad++;
            if (rd_addr >= 7'h40) mon_fac++;
            mon_next++;
            mon_cnt++;
        end
    end

    function automatic logic [15:0] model();
        logic [15:0] a = 16'hAAAA;
        for (int i = 0; i < 63; i++) begin
            a = a ^ mem[i];
            a = {a[14:0], a[15]};
        end
        return a;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // poke: 0 none, 1 mid-walk, 2 on last read, 3 in drain cycle
    task automatic run(input int poke);
        logic [15:0] exp;
        bit          exp_m;
        int          cyc;
        exp   = model();
        exp_m = (exp == mem[63]);
        @(negedge clk);
        mon_next = 0; mon_bad = 0; mon_fac = 0; mon_cnt = 0;
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if ((poke == 1 && cyc == 20) || (poke == 2 && cyc == 64) || (poke == 3 && cyc == 65))
                start = 1'b1;
        end while (!done && cyc < 200);
        start = 1'b0;
        // start accepted at edge E0; done follows edge E65, seen at negedge 66
        chk(cyc == 66, "R7 latency", cyc, 66);
        chk(result == exp, "R3 result", result, exp);
        chk(match == exp_m, "R8 match", match, exp_m);
        chk(mon_bad == 0 && mon_cnt == 64, "R4 address order", mon_cnt, 64);
        chk(mon_fac == 0, "R5 factory untouched", mon_fac, 0);
        @(negedge clk);
        chk(!done, "R7 done one cycle", done, 0);
        chk(!rd_en, "R9 no restart", rd_en, 0);
        chk(result == exp && match == exp_m, "R8 hold", result, exp);
    endtask

    initial begin
        #(5ns * 180000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] r0, r1;
        for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
        rst = 1'b1; start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(result == 16'hAAAA, "R1 reset result", result, 16'hAAAA);
        chk(!rd_en && !done && !match, "R1 reset outputs", {rd_en, done, match}, 0);

        // all zero: 63 rotations of 0xAAAA give 0x5555 (R3)
        mem[63] = 16'h5555;
        run(0);
        chk(result == 16'h5555, "R3 zero store", result, 16'h5555);
        for (int i = 0; i < 63; i++) mem[i] = 16'hFFFF;
        mem[63] = 16'h0000;
        run(0);

        // walking single bit across every covered word (R3, R2)
        for (int i = 0; i < 128; i++) mem[i] = 16'h0000;
        for (int w = 0; w < 63; w++) begin
            for (int b = 0; b < 16; b++) begin
                mem[w] = 16'h1 << b;
                run(0);
            end
            mem[w] = 16'h0000;
        end

        // random stores, correct and corrupted check word (R8, R6)
        for (int t = 0; t < 20; t++) begin
            for (int i = 0; i < 128; i++) mem[i] = 16'($urandom);
            mem[63] = model();
            run(t % 4);
            chk(match == 1'b1, "R8 correct word matches", match, 1);
            r0 = result;
            mem[63] = mem[63] ^ 16'h0100;
            run(0);
            chk(match == 1'b0 && result == r0, "R6 check word excluded", result, r0);
            // R5: new factory contents, same result
            for (int i = 64; i < 128; i++) mem[i] = 16'($urandom);
            run(0);
            r1 = result;
            chk(r1 == r0, "R5 factory ignored", r1, r0);
        end

        // R9: pokes during the walk and in the tail
        for (int p = 1; p < 4; p++) run(p);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule